// File: doc/BRIEF.md
# MII PHY-Mode Data Path Controller

This block lets an internal switch port appear as a PHY to an external MAC attached over a nibble-wide MII. In normal operation it carries the MAC's transmit nibbles into the switch's receive side and the switch's transmit nibbles onto the MAC's receive side. It generates carrier sense and collision toward both parties from the transmit activity it sees.

Control bits select several test behaviours. Loopback returns the MAC's own frames to it. Two collision tests force a collision toward the MAC or toward the switch. Isolate disables the MAC-facing pins. Two further bits report the configured line rate, which is 10, 100 or 200 Mbps. Every data-path output is registered, so a result appears one clock after the input that caused it.

Top module: `mii_phy_path`

## Requirements
- R1: While rst_n is low, and in the first sampling after reset, all registered data, valid, error, carrier and collision outputs are 0.
- R2: With loopback and isolate off, sw_rxd/sw_rxdv/sw_rxer equal the previous cycle's mac_txd/mac_txen/mac_txer when mac_txen was 1 (all zero otherwise), and mac_rxd/mac_rxdv equal the previous cycle's sw_txd/sw_txen, with mac_rxer 0.
- R3: mac_crs is 1 one clock after the MAC or the switch transmits. The switch's activity does not count toward it during loopback. sw_crs is 1 one clock after the switch transmits, or after a forwarded MAC transmission.
- R4: In half duplex (cfg_full_duplex=0), with no test mode forcing a collision, mac_col and sw_col rise one clock after the MAC and the switch both transmit. In full duplex, neither is raised by simultaneous transmission.
- R5: With loopback on and isolate off, mac_rxd/mac_rxdv/mac_rxer equal the previous cycle's mac_txd/mac_txen/mac_txer, and the switch's transmit data is not sent to the MAC.
- R6: With loopback on, MAC transmissions produce no sw_rxdv, sw_rxer, sw_rxd, sw_crs or sw_col activity.
- R7: With cfg_coltest_mac=1 and isolate off, any MAC transmission raises mac_col one clock later, in any duplex mode.
- R8: With cfg_coltest_sw=1, any switch transmission raises sw_col one clock later, whatever the isolate setting.
- R9: With isolate on, the MAC inputs are ignored, and mac_rxd, mac_rxdv, mac_rxer, mac_crs and mac_col are 0 one clock later.
- R10: mac_oe equals the inverse of cfg_isolate as sampled at the previous clock edge.
- R11: rate_sel is 0 (10 Mbps) when cfg_speed_hi=0, 1 (100 Mbps) when cfg_speed_hi=1 and cfg_turbo=0, and 2 (200 Mbps) when both are 1. It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_loop_mac | input | 1 | Return MAC frames to the MAC |
| cfg_coltest_mac | input | 1 | Force collision to MAC on its transmits |
| cfg_coltest_sw | input | 1 | Force collision to switch on its transmits |
| cfg_isolate | input | 1 | Disable MAC-facing pins |
| cfg_full_duplex | input | 1 | Full duplex when 1 |
| cfg_speed_hi | input | 1 | Fast rate select |
| cfg_turbo | input | 1 | Fast rate means 200 Mbps |
| mac_txd | input | 4 | MAC transmit nibble |
| mac_txen | input | 1 | MAC transmit valid |
| mac_txer | input | 1 | MAC transmit error |
| sw_txd | input | 4 | Switch transmit nibble |
| sw_txen | input | 1 | Switch transmit valid |
| mac_rxd | output | 4 | Receive nibble to MAC |
| mac_rxdv | output | 1 | Receive valid to MAC |
| mac_rxer | output | 1 | Receive error to MAC |
| mac_crs | output | 1 | Carrier sense to MAC |
| mac_col | output | 1 | Collision to MAC |
| mac_oe | output | 1 | Output enable of MAC-facing pins |
| sw_rxd | output | 4 | Receive nibble to switch |
| sw_rxdv | output | 1 | Receive valid to switch |
| sw_rxer | output | 1 | Receive error to switch |
| sw_crs | output | 1 | Carrier sense to switch |
| sw_col | output | 1 | Collision to switch |
| rate_sel | output | 2 | Configured rate code |

## Verification
Every data, carrier, collision and enable output is due exactly one clock after the inputs that cause it. rate_sel is due in the same cycle. The bench drives all inputs on the falling edge and keeps a copy of them. At the next falling edge it compares each registered output with a value computed from that copy, so exactly one rising edge lies between stimulus and check. rate_sel is compared one nanosecond after each drive, before any rising edge.

// File: rtl/mii_phy_path.sv
module mii_phy_path (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_loop_mac,
  input  logic       cfg_coltest_mac,
  input  logic       cfg_coltest_sw,
  input  logic       cfg_isolate,
  input  logic       cfg_full_duplex,
  input  logic       cfg_speed_hi,
  input  logic       cfg_turbo,
  input  logic [3:0] mac_txd,
  input  logic       mac_txen,
  input  logic       mac_txer,
  input  logic [3:0] sw_txd,
  input  logic       sw_txen,
  output logic [3:0] mac_rxd,
  output logic       mac_rxdv,
  output logic       mac_rxer,
  output logic       mac_crs,
  output logic       mac_col,
  output logic       mac_oe,
  output logic [3:0] sw_rxd,
  output logic       sw_rxdv,
  output logic       sw_rxer,
  output logic       sw_crs,
  output logic       sw_col,
  output logic [1:0] rate_sel
);

  logic [3:0] m_d;
  logic       m_en, m_er, fwd_en, sw_act, half;

  assign m_d    = cfg_isolate ? 4'd0 : mac_txd;
  assign m_en   = mac_txen & ~cfg_isolate;
  assign m_er   = mac_txer & ~cfg_isolate;
  assign fwd_en = m_en & ~cfg_loop_mac;
  assign sw_act = sw_txen & ~cfg_loop_mac;
  assign half   = ~cfg_full_duplex;

  assign rate_sel = !cfg_speed_hi ? 2'd0 : (cfg_turbo ? 2'd2 : 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mac_rxd  <= '0;
      mac_rxdv <= 1'b0;
      mac_rxer <= 1'b0;
      mac_crs  <= 1'b0;
      mac_col  <= 1'b0;
      sw_rxd   <= '0;
      sw_rxdv  <= 1'b0;
      sw_rxer  <= 1'b0;
      sw_crs   <= 1'b0;
      sw_col   <= 1'b0;
    end else begin
      if (cfg_isolate) begin
        mac_rxd  <= '0;
        mac_rxdv <= 1'b0;
        mac_rxer <= 1'b0;
      end else if (cfg_loop_mac) begin
        mac_rxd  <= m_d;
        mac_rxdv <= m_en;
        mac_rxer <= m_er;
      end else begin
        mac_rxd  <= sw_txd;
        mac_rxdv <= sw_txen;
        mac_rxer <= 1'b0;
      end
      mac_crs <= ~cfg_isolate & (m_en | sw_act);
      mac_col <= ~cfg_isolate & ((cfg_coltest_mac & m_en) | (half & m_en & sw_act));
      sw_rxd  <= fwd_en ? m_d : 4'd0;
      sw_rxdv <= fwd_en;
      sw_rxer <= fwd_en & m_er;
      sw_crs  <= fwd_en | sw_txen;
      sw_col  <= (cfg_coltest_sw & sw_txen) | (half & fwd_en & sw_txen);
    end
  end

  always_ff @(posedge clk) mac_oe <= ~cfg_isolate;

endmodule

module mii_phy_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_loop_mac,
  input logic       cfg_coltest_mac,
  input logic       cfg_coltest_sw,
  input logic       cfg_isolate,
  input logic       cfg_full_duplex,
  input logic [3:0] mac_txd,
  input logic       mac_txen,
  input logic       sw_txen,
  input logic [3:0] mac_rxd,
  input logic       mac_rxdv,
  input logic       mac_crs,
  input logic       mac_col,
  input logic       mac_oe,
  input logic       sw_rxdv,
  input logic       sw_col
);
  a_r5_loop_echo: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loop_mac && !cfg_isolate |=> mac_rxd == $past(mac_txd) && mac_rxdv == $past(mac_txen));
  a_r6_loop_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loop_mac |=> !sw_rxdv);
  a_r7_mac_coltest: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_coltest_mac && mac_txen && !cfg_isolate |=> mac_col);
  a_r8_sw_coltest: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_coltest_sw && sw_txen |=> sw_col);
  a_r9_isolate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_isolate |=> !mac_rxdv && !mac_crs && !mac_col);
  a_r4_fdx_no_col: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_full_duplex && !cfg_coltest_mac |=> !mac_col);
  a_r10_oe_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mac_oe == !$past(cfg_isolate));
endmodule

bind mii_phy_path mii_phy_path_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_loop_mac(cfg_loop_mac),
  .cfg_coltest_mac(cfg_coltest_mac), .cfg_coltest_sw(cfg_coltest_sw),
  .cfg_isolate(cfg_isolate), .cfg_full_duplex(cfg_full_duplex),
  .mac_txd(mac_txd), .mac_txen(mac_txen), .sw_txen(sw_txen),
  .mac_rxd(mac_rxd), .mac_rxdv(mac_rxdv), .mac_crs(mac_crs),
  .mac_col(mac_col), .mac_oe(mac_oe), .sw_rxdv(sw_rxdv), .sw_col(sw_col)
);

// File: tb/sim_mii_phy_path.sv
`timescale 1ns/1ps
module sim_mii_phy_path;
  logic clk = 1'b0, rst_n = 1'b0;
  logic loop, ctm, cts, iso, fdx, spd, tur;
  logic [3:0] mtxd, stxd;
  logic mten, mter, sten;
  logic [3:0] mac_rxd, sw_rxd;
  logic mac_rxdv, mac_rxer, mac_crs, mac_col, mac_oe;
  logic sw_rxdv, sw_rxer, sw_crs, sw_col;
  logic [1:0] rate_sel;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  mii_phy_path u0 (
    .clk(clk), .rst_n(rst_n), .cfg_loop_mac(loop), .cfg_coltest_mac(ctm),
    .cfg_coltest_sw(cts), .cfg_isolate(iso), .cfg_full_duplex(fdx),
    .cfg_speed_hi(spd), .cfg_turbo(tur), .mac_txd(mtxd), .mac_txen(mten),
    .mac_txer(mter), .sw_txd(stxd), .sw_txen(sten), .mac_rxd(mac_rxd),
    .mac_rxdv(mac_rxdv), .mac_rxer(mac_rxer), .mac_crs(mac_crs),
    .mac_col(mac_col), .mac_oe(mac_oe), .sw_rxd(sw_rxd), .sw_rxdv(sw_rxdv),
    .sw_rxer(sw_rxer), .sw_crs(sw_crs), .sw_col(sw_col), .rate_sel(rate_sel));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rate(input logic s, input logic t);
    if (!s) return 0;
    return t ? 2 : 1;
  endfunction

  // Check all registered outputs against the inputs driven one edge earlier.
  task automatic check_prev(input logic l, input logic cm, input logic cs, input logic i,
                            input logic f, input logic [3:0] md, input logic me,
                            input logic mr, input logic [3:0] sd, input logic se);
    logic men, mer, fwd, sact, ecol;
    logic [3:0] emd;
    men  = me & !i;
    mer  = mr & !i;
    fwd  = men & !l;
    sact = se & !l;
    if (i) begin
      chk("R9 mac_rxd", mac_rxd, 0);
      chk("R9 mac_rxdv", mac_rxdv, 0);
      chk("R9 mac_rxer", mac_rxer, 0);
      chk("R9 mac_crs", mac_crs, 0);
      chk("R9 mac_col", mac_col, 0);
    end else begin
      emd = l ? md : sd;
      if (l) begin
        chk("R5 mac_rxd", mac_rxd, emd);
        chk("R5 mac_rxdv", mac_rxdv, me);
        chk("R5 mac_rxer", mac_rxer, mr);
      end else begin
        chk("R2 mac_rxd", mac_rxd, emd);
        chk("R2 mac_rxdv", mac_rxdv, se);
        chk("R2 mac_rxer", mac_rxer, 0);
      end
      chk("R3 mac_crs", mac_crs, int'(men | sact));
      ecol = (cm & men) | (!f & men & sact);
      if (cm) chk("R7 mac_col", mac_col, int'(ecol));
      else    chk("R4 mac_col", mac_col, int'(ecol));
    end
    if (l) begin
      chk("R6 sw_rxdv", sw_rxdv, 0);
      chk("R6 sw_rxer", sw_rxer, 0);
      chk("R6 sw_rxd", sw_rxd, 0);
      chk("R6 sw_crs", sw_crs, int'(se));
    end else begin
      chk("R2 sw_rxdv", sw_rxdv, int'(fwd));
      chk("R2 sw_rxer", sw_rxer, int'(fwd & mer));
      chk("R2 sw_rxd", sw_rxd, fwd ? int'(md) : 0);
      chk("R3 sw_crs", sw_crs, int'(fwd | se));
    end
    ecol = (cs & se) | (!f & fwd & se);
    if (cs) chk("R8 sw_col", sw_col, int'(ecol));
    else    chk("R4 sw_col", sw_col, int'(ecol));
    chk("R10 mac_oe", mac_oe, int'(!i));
  endtask

  // Apply one cycle of stimulus and check the outcome at the next falling edge.
  task automatic step(input logic l, input logic cm, input logic cs, input logic i,
                      input logic f, input logic s, input logic t, input logic [3:0] md,
                      input logic me, input logic mr, input logic [3:0] sd, input logic se);
    loop = l; ctm = cm; cts = cs; iso = i; fdx = f; spd = s; tur = t;
    mtxd = md; mten = me; mter = mr; stxd = sd; sten = se;
    #1;
    chk("R11 rate_sel", rate_sel, exp_rate(s, t));
    @(negedge clk);
    check_prev(l, cm, cs, i, f, md, me, mr, sd, se);
  endtask

  initial begin
    logic l, cm, cs, i, f, s, t;
    void'($urandom(32'd1234));
    loop = 0; ctm = 0; cts = 0; iso = 0; fdx = 0; spd = 0; tur = 0;
    mtxd = 4'hF; mten = 1; mter = 1; stxd = 4'hA; sten = 1;
    repeat (3) @(negedge clk);
    // R1: reset holds everything low despite active inputs
    chk("R1 mac_rxdv", mac_rxdv, 0);
    chk("R1 mac_crs", mac_crs, 0);
    chk("R1 mac_col", mac_col, 0);
    chk("R1 sw_rxdv", sw_rxdv, 0);
    chk("R1 sw_col", sw_col, 0);
    chk("R1 mac_rxd", mac_rxd, 0);
    mten = 0; mter = 0; sten = 0;
    @(negedge clk);
    rst_n = 1;
    // Directed corners
    step(0,0,0,0,0,0,0, 4'h5,1,0, 4'h3,1); // R4 half-duplex collision
    step(0,0,0,0,1,1,0, 4'h5,1,0, 4'h3,1); // R4 full duplex, no collision
    step(1,0,0,0,0,1,1, 4'h9,1,1, 4'h6,1); // R5/R6 loopback
    step(0,1,0,0,1,1,1, 4'h2,1,0, 4'h0,0); // R7 MAC collision test in full duplex
    step(0,0,1,1,0,0,1, 4'h7,1,1, 4'h1,1); // R8 switch test under isolate, R9
    step(0,0,0,1,0,0,0, 4'hC,1,1, 4'h4,0); // R9 isolate ignores MAC
    step(0,0,0,0,0,1,1, 4'h0,0,0, 4'hE,1); // R10 enable back on
    // Random phase
    l = 0; cm = 0; cs = 0; i = 0; f = 0; s = 0; t = 0;
    for (int k = 0; k < 3000; k++) begin
      if (k % 16 == 0) begin
        l  = ($urandom % 4) == 0;
        cm = ($urandom % 4) == 0;
        cs = ($urandom % 4) == 0;
        i  = ($urandom % 6) == 0;
        f  = ($urandom % 2) == 0;
        s  = ($urandom % 2) == 0;
        t  = ($urandom % 2) == 0;
      end
      step(l, cm, cs, i, f, s, t, 4'($urandom), 1'($urandom), ($urandom % 8) == 0,
           4'($urandom), 1'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule